// File: doc/BRIEF.md
# Dual-Limit Watchdog Window Comparator

This block runs one watchdog instruction at a time against a stream of signed digital samples. Each instruction makes two comparisons, one after the other. The first comparison is against a first limit and the second is against a second limit. Each limit has its own direction bit. That bit decides whether the limit trips when the sample is above it or when the sample is below it. A trip sets a sticky flag for that limit in a status word. The status word also holds the pointer of the instruction that tripped. While any flag is set, an interrupt request stays raised.

An instruction can start in one of two ways, chosen by a sync-direction input. In output mode a start strobe begins the instruction, and the block drives a sync output high for the whole instruction. In input mode a rising edge on a sync input begins the instruction. When auto-zero is enabled, a fixed number of auto-zero cycles, marked by a strobe, comes before each of the two comparisons. The instruction memory and the sample source sit outside the block and reach it as plain ports. The limits, the direction bits, the pointer and the auto-zero enable are latched when the instruction starts. The sample is read during each comparison cycle.

Top module: `wdog_window_cmp`

## Requirements
- R1: A start runs one instruction. Without auto-zero, busy_o is high for exactly 2 cycles: the limit-1 comparison and then the limit-2 comparison. With auto-zero, busy_o is high for 2+2*AZ_CYCLES cycles, and limit 1 is always compared before limit 2.
- R2: With its direction bit at 1, a limit trips when the sample is strictly greater than the limit. With the bit at 0, it trips when the sample is strictly less. Samples and limits are DW-bit two's complement values compared as signed, and equality never trips.
- R3: stat_o bit 0 is the limit-1 flag and bit 1 is the limit-2 flag. Bits [PTR_W+1:2] hold the pointer latched by the most recent instruction that tripped a limit. Each flag is set in the cycle after its comparison.
- R4: irq_o is high exactly while a limit flag in stat_o is set.
- R5: With sync_dir_i=1, sync_out_o is high from the cycle after the start through the last comparison cycle. sync_out_o is low whenever the block is idle, and always low with sync_dir_i=0.
- R6: With sync_dir_i=0, only a rising edge of sync_in_i starts an instruction and start_i is ignored. With sync_dir_i=1, only start_i starts one and sync_in_i is ignored.
- R7: With auto-zero enabled at the start, az_strobe_o is high for AZ_CYCLES cycles before each comparison and is never high during a comparison. With auto-zero disabled, az_strobe_o stays low.
- R8: Flags accumulate across instructions until stat_rd_i is high for a cycle, which clears the whole status word at the next edge. A trip in that same cycle still sets its flag and pointer.
- R9: A start request while busy_o is high is ignored.
- R10: After reset the block is idle: busy_o, sync_out_o, az_strobe_o and irq_o are low and stat_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, used in output mode |
| sync_dir_i | input | 1 | 1: sync is an output, 0: sync is an input |
| sync_in_i | input | 1 | Sync input; a rising edge starts in input mode |
| sync_out_o | output | 1 | High during an instruction in output mode |
| autozero_en_i | input | 1 | Insert auto-zero before each comparison |
| az_strobe_o | output | 1 | High during auto-zero cycles |
| instr_ptr_i | input | PTR_W | Pointer of the instruction being started |
| limit1_i | input | DW | First limit, signed |
| limit2_i | input | DW | Second limit, signed |
| above1_i | input | 1 | Limit-1 direction: 1 above, 0 below |
| above2_i | input | 1 | Limit-2 direction: 1 above, 0 below |
| sample_i | input | DW | Signed sample read in each comparison cycle |
| busy_o | output | 1 | Instruction in progress |
| stat_rd_i | input | 1 | Status read strobe; clears the status |
| stat_o | output | PTR_W+2 | {pointer, limit-2 flag, limit-1 flag} |
| irq_o | output | 1 | Limit-crossing interrupt request |

## Verification
The first busy cycle is the cycle after the start edge. The limit-1 comparison comes 1+AZ_CYCLES cycles after the start edge with auto-zero, or 1 cycle after it without. The limit-1 flag appears one cycle after that comparison. The limit-2 comparison follows AZ_CYCLES+1 cycles after the limit-1 comparison with auto-zero, or 1 cycle after it without, and busy_o falls in the cycle after the limit-2 comparison. The bench drives each input and reads each output at the falling edge. It walks through the schedule one cycle at a time: it checks busy, the strobe and sync in every cycle, changes the sample right after the limit-1 comparison, and checks status and interrupt only after the final edge. A read is checked for its value before the edge and for a cleared word after it.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_AZ1  = 3'd1,
    ST_CMP1 = 3'd2,
    ST_AZ2  = 3'd3,
    ST_CMP2 = 3'd4
  } wwc_state_e;

  // Trip rule: strict above or strict below, on sign-extended values.
  function automatic logic wwc_trips(input logic signed [31:0] smp,
                                     input logic signed [31:0] lim,
                                     input logic               above);
    logic gt, lt;
    gt = (smp > lim);
    lt = (smp < lim);
    return above ? gt : lt;
  endfunction

endpackage

// File: rtl/wwc_seq.sv
module wwc_seq #(
  parameter int AZ_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                sync_dir_i,
  input  logic                sync_in_i,
  input  logic                az_en_i,
  output wwc_pkg::wwc_state_e state_o,
  output logic                start_evt_o
);
  import wwc_pkg::*;

  localparam int CW = $clog2(AZ_CYCLES + 1);
  localparam logic [CW-1:0] AZ_LOAD = CW'(AZ_CYCLES - 1);

  wwc_state_e    state_q;
  logic          sync_q;
  logic          az_en_q;
  logic [CW-1:0] cnt_q;
  logic          req;

  assign req         = sync_dir_i ? start_i : (sync_in_i && !sync_q);
  assign start_evt_o = (state_q == ST_IDLE) && req;
  assign state_o     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sync_q  <= 1'b0;
      az_en_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= sync_in_i;
      unique case (state_q)
        ST_IDLE: begin
          if (start_evt_o) begin
            az_en_q <= az_en_i;
            cnt_q   <= AZ_LOAD;
            state_q <= az_en_i ? ST_AZ1 : ST_CMP1;
          end
        end
        ST_AZ1: begin
          if (cnt_q == '0) state_q <= ST_CMP1;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_CMP1: begin
          cnt_q   <= AZ_LOAD;
          state_q <= az_en_q ? ST_AZ2 : ST_CMP2;
        end
        ST_AZ2: begin
          if (cnt_q == '0) state_q <= ST_CMP2;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_CMP2: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wwc_cmp.sv
module wwc_cmp #(
  parameter int DW = 13
) (
  input  logic          en_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] limit_i,
  input  logic          above_i,
  output logic          hit_o
);
  import wwc_pkg::*;

  logic signed [31:0] smp_x, lim_x;

  assign smp_x = 32'(signed'(sample_i));
  assign lim_x = 32'(signed'(limit_i));
  assign hit_o = en_i && wwc_trips(smp_x, lim_x, above_i);

endmodule

// File: rtl/wwc_status.sv
module wwc_status #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       hit_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             rd_i,
  output logic [PTR_W+1:0] stat_o,
  output logic             irq_o
);

  logic [1:0]       flags_q;
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ptr_q   <= '0;
    end else begin
      logic [1:0]       f_n;
      logic [PTR_W-1:0] p_n;
      f_n = rd_i ? 2'b00 : flags_q;
      p_n = rd_i ? '0 : ptr_q;
      if (|hit_i) p_n = ptr_i;
      flags_q <= f_n | hit_i;
      ptr_q   <= p_n;
    end
  end

  assign stat_o = {ptr_q, flags_q};
  assign irq_o  = |flags_q;

endmodule

// File: rtl/wdog_window_cmp.sv
module wdog_window_cmp #(
  parameter int DW        = 13,
  parameter int PTR_W     = 3,
  parameter int AZ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sync_dir_i,
  input  logic             sync_in_i,
  output logic             sync_out_o,
  input  logic             autozero_en_i,
  output logic             az_strobe_o,
  input  logic [PTR_W-1:0] instr_ptr_i,
  input  logic [DW-1:0]    limit1_i,
  input  logic [DW-1:0]    limit2_i,
  input  logic             above1_i,
  input  logic             above2_i,
  input  logic [DW-1:0]    sample_i,
  output logic             busy_o,
  input  logic             stat_rd_i,
  output logic [PTR_W+1:0] stat_o,
  output logic             irq_o
);
  import wwc_pkg::*;

  localparam int NLIM = 2;

  wwc_state_e       state;
  logic             start_evt;
  logic             cmp1_act, cmp2_act, az_act;
  logic             hit1_evt, hit2_evt;
  logic [NLIM-1:0]  cmp_act;
  logic [NLIM-1:0]  hit_evt;
  logic [DW-1:0]    lim_q   [NLIM];
  logic [NLIM-1:0]  above_q;
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    lim_in  [NLIM];
  logic [NLIM-1:0]  above_in;

  assign lim_in[0] = limit1_i;
  assign lim_in[1] = limit2_i;
  assign above_in  = {above2_i, above1_i};

  wwc_seq #(.AZ_CYCLES(AZ_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sync_dir_i  (sync_dir_i),
    .sync_in_i   (sync_in_i),
    .az_en_i     (autozero_en_i),
    .state_o     (state),
    .start_evt_o (start_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLIM; i++) lim_q[i] <= '0;
      above_q <= '0;
      ptr_q   <= '0;
    end else if (start_evt) begin
      for (int i = 0; i < NLIM; i++) lim_q[i] <= lim_in[i];
      above_q <= above_in;
      ptr_q   <= instr_ptr_i;
    end
  end

  assign cmp1_act   = (state == ST_CMP1);
  assign cmp2_act   = (state == ST_CMP2);
  assign az_act     = (state == ST_AZ1) || (state == ST_AZ2);
  assign cmp_act    = {cmp2_act, cmp1_act};

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    wwc_cmp #(.DW(DW)) u_cmp (
      .en_i     (cmp_act[g]),
      .sample_i (sample_i),
      .limit_i  (lim_q[g]),
      .above_i  (above_q[g]),
      .hit_o    (hit_evt[g])
    );
  end

  assign hit1_evt = hit_evt[0];
  assign hit2_evt = hit_evt[1];

  wwc_status #(.PTR_W(PTR_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit_evt),
    .ptr_i  (ptr_q),
    .rd_i   (stat_rd_i),
    .stat_o (stat_o),
    .irq_o  (irq_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign az_strobe_o = az_act;
  assign sync_out_o  = sync_dir_i && busy_o;

endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_dir_i,
  input logic             sync_out_o,
  input logic             busy_o,
  input logic             az_strobe_o,
  input logic             irq_o,
  input logic             stat_rd_i,
  input logic [PTR_W+1:0] stat_o,
  input logic             start_evt,
  input logic             cmp1_act,
  input logic             cmp2_act,
  input logic             az_act,
  input logic             hit1_evt,
  input logic             hit2_evt
);

  a_r1_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cmp1_act || az_act));

  a_r1_cmp2_order: assert property (@(posedge clk) disable iff (!rst_n)
    cmp2_act |-> ($past(cmp1_act) || $past(az_act)));

  a_r3_flag1_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit1_evt |=> stat_o[0]);

  a_r3_flag2_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit2_evt |=> stat_o[1]);

  a_r4_irq_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1_evt || hit2_evt) |=> irq_o);

  a_r5_sync_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && sync_dir_i) |=> sync_out_o);

  a_r5_sync_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sync_out_o);

  a_r7_az_apart: assert property (@(posedge clk) disable iff (!rst_n)
    az_strobe_o |-> !(cmp1_act || cmp2_act));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !hit1_evt && !hit2_evt) |=> (stat_o == '0));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_evt);

endmodule

bind wdog_window_cmp wwc_checker #(.PTR_W(PTR_W)) u_wwc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_dir_i  (sync_dir_i),
  .sync_out_o  (sync_out_o),
  .busy_o      (busy_o),
  .az_strobe_o (az_strobe_o),
  .irq_o       (irq_o),
  .stat_rd_i   (stat_rd_i),
  .stat_o      (stat_o),
  .start_evt   (start_evt),
  .cmp1_act    (cmp1_act),
  .cmp2_act    (cmp2_act),
  .az_act      (az_act),
  .hit1_evt    (hit1_evt),
  .hit2_evt    (hit2_evt)
);

// File: tb/test_wdog_window_cmp.sv
module test_wdog_window_cmp;

  localparam int DW = 13;
  localparam int PW = 3;
  localparam int AZ = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, sync_dir_i = 1'b1, sync_in_i = 1'b0;
  logic          autozero_en_i = 1'b0, above1_i = 1'b0, above2_i = 1'b0;
  logic [PW-1:0] instr_ptr_i = '0;
  logic [DW-1:0] limit1_i = '0, limit2_i = '0, sample_i = '0;
  logic          stat_rd_i = 1'b0;
  logic          sync_out_o, az_strobe_o, busy_o, irq_o;
  logic [PW+1:0] stat_o;

  int checks = 0;
  int errors = 0;
  logic [PW+1:0] exp_stat = '0;

  always #10 clk = ~clk;

  wdog_window_cmp #(.DW(DW), .PTR_W(PW), .AZ_CYCLES(AZ)) i_wdog_window_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sync_dir_i(sync_dir_i),
    .sync_in_i(sync_in_i), .sync_out_o(sync_out_o),
    .autozero_en_i(autozero_en_i), .az_strobe_o(az_strobe_o),
    .instr_ptr_i(instr_ptr_i), .limit1_i(limit1_i), .limit2_i(limit2_i),
    .above1_i(above1_i), .above2_i(above2_i), .sample_i(sample_i),
    .busy_o(busy_o), .stat_rd_i(stat_rd_i), .stat_o(stat_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit trip(input int s, input int l, input bit above);
    if (above) return s > l;
    return s < l;
  endfunction

  // Read-and-clear the status, checking the value seen before the edge.
  task automatic read_stat(input string req);
    @(negedge clk);
    stat_rd_i = 1'b1;
    chk(stat_o == exp_stat, req, int'(stat_o), int'(exp_stat));
    chk(irq_o == |exp_stat[1:0], "R4", int'(irq_o), int'(|exp_stat[1:0]));
    @(negedge clk);
    stat_rd_i = 1'b0;
    exp_stat = '0;
    chk(stat_o == '0, "R8", int'(stat_o), 0);
    chk(irq_o == 1'b0, "R4", int'(irq_o), 0);
  endtask

  // One watchdog instruction; rd2 asserts the read during the second comparison.
  task automatic run_wd(input int l1, input int l2, input bit a1, input bit a2,
                        input int s1, input int s2, input int ptr,
                        input bit az, input bit sdir, input bit rd2);
    bit h1, h2;
    h1 = trip(s1, l1, a1);
    h2 = trip(s2, l2, a2);
    @(negedge clk);
    limit1_i = DW'(l1); limit2_i = DW'(l2);
    above1_i = a1; above2_i = a2;
    sample_i = DW'(s1);
    instr_ptr_i = PW'(ptr);
    autozero_en_i = az;
    sync_dir_i = sdir;
    if (sdir) start_i = 1'b1;
    else sync_in_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    sync_in_i = 1'b0;
    for (int ph = 0; ph < 2; ph++) begin
      if (az) begin
        for (int k = 0; k < AZ; k++) begin
          chk(busy_o, "R1", int'(busy_o), 1);
          chk(az_strobe_o, "R7", int'(az_strobe_o), 1);
          chk(sync_out_o == sdir, "R5", int'(sync_out_o), int'(sdir));
          @(negedge clk);
        end
      end
      chk(busy_o, "R1", int'(busy_o), 1);
      chk(!az_strobe_o, "R7", int'(az_strobe_o), 0);
      chk(sync_out_o == sdir, "R5", int'(sync_out_o), int'(sdir));
      if (ph == 1 && rd2) stat_rd_i = 1'b1;
      @(negedge clk);
      stat_rd_i = 1'b0;
      if (ph == 0) begin
        sample_i = DW'(s2);
        if (h1) begin exp_stat[0] = 1'b1; exp_stat[PW+1:2] = PW'(ptr); end
        chk(stat_o[0] == exp_stat[0], "R3", int'(stat_o[0]), int'(exp_stat[0]));
      end
    end
    if (rd2) exp_stat = '0;
    if (h2) begin exp_stat[1] = 1'b1; exp_stat[PW+1:2] = PW'(ptr); end
    chk(!busy_o, "R1", int'(busy_o), 0);
    chk(!sync_out_o, "R5", int'(sync_out_o), 0);
    chk(stat_o == exp_stat, "R2/R3", int'(stat_o), int'(exp_stat));
    chk(irq_o == |exp_stat[1:0], "R4", int'(irq_o), int'(|exp_stat[1:0]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lims[5];
    int smps[12];
    int idx;
    lims = '{-4096, -1, 0, 7, 4095};
    smps = '{-4096, -4095, -2, -1, 0, 1, 2, 6, 7, 8, 4094, 4095};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !sync_out_o && !az_strobe_o, "R10", int'(busy_o), 0);
    chk(stat_o == '0 && !irq_o, "R10", int'(stat_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && stat_o == '0, "R10", int'(busy_o), 0);

    // R1/R2/R3: sweep limits, samples and directions on both limits
    idx = 0;
    foreach (lims[li]) begin
      foreach (smps[si]) begin
        for (int a = 0; a < 2; a++) begin
          run_wd(lims[li], -lims[li] - 1, bit'(a), bit'(1 - a),
                 smps[si], smps[si], idx % 8, (idx % 3) == 0, (idx % 2) == 1, 1'b0);
          read_stat("R3");
          idx++;
        end
      end
    end

    // R8: accumulation across instructions, pointer from latest trip
    run_wd(0, 0, 1'b1, 1'b1, 5, -5, 3, 1'b0, 1'b1, 1'b0);
    run_wd(0, 0, 1'b1, 1'b0, -5, -5, 5, 1'b1, 1'b1, 1'b0);
    chk(stat_o == {3'd5, 2'b11}, "R8", int'(stat_o), int'({3'd5, 2'b11}));
    run_wd(0, 0, 1'b1, 1'b1, -1, -1, 6, 1'b0, 1'b1, 1'b0);
    chk(stat_o == {3'd5, 2'b11}, "R8", int'(stat_o), int'({3'd5, 2'b11}));
    read_stat("R8");

    // R8: trip in the read cycle survives the clear
    run_wd(0, 0, 1'b1, 1'b1, 9, 9, 2, 1'b0, 1'b1, 1'b1);
    chk(stat_o == {3'd2, 2'b10}, "R8", int'(stat_o), int'({3'd2, 2'b10}));
    read_stat("R8");

    // R6: start_i ignored in input mode, sync_in_i ignored in output mode
    @(negedge clk);
    sync_dir_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o, "R6", int'(busy_o), 0);
    sync_dir_i = 1'b1; sync_in_i = 1'b1;
    @(negedge clk);
    sync_in_i = 1'b0;
    chk(!busy_o, "R6", int'(busy_o), 0);
    chk(!sync_out_o, "R5", int'(sync_out_o), 0);

    // R9: start held through a busy instruction is ignored
    @(negedge clk);
    autozero_en_i = 1'b0; sync_dir_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o, "R9", int'(busy_o), 1);
    @(negedge clk);
    chk(busy_o, "R9", int'(busy_o), 1);
    start_i = 1'b0;
    @(negedge clk);
    chk(!busy_o, "R9", int'(busy_o), 0);
    @(negedge clk);
    chk(!busy_o, "R9", int'(busy_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule